// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block sits beside a memory port and watches the accesses that reach it. Each cycle in which the access strobe is high counts as one access, qualified as a read or a write. A command is recognised only when six consecutive accesses are reads. The first five must hit a fixed chain of key addresses, and the sixth must hit one of four command addresses. The sixth address selects what the command is: write the array to nonvolatile storage, restore it from storage, turn the automatic power-loss store off, or turn it on again.

When the chain completes, the detector raises a one-cycle pulse together with a two-bit command code. The controller that runs the storage operation consumes this pulse. While that operation is running, the controller holds a busy input high. The detector then ignores every access and drops any partial match.

Only the low 16 bits of the address take part in matching. The address bus itself may be wider. A read that misses the expected address aborts the chain, and so does any write. A sixth read that matches none of the command addresses also aborts the chain. Idle cycles between accesses do not disturb a partial match. This means the strobe may come from either the chip-enable or the output-enable path.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, `cmd_valid` and `cmd_code` are 0 and no partial match is held, so a lone command-address read issues nothing.
- R2: Five reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, in that order, followed by a read at a command address make `cmd_valid` high in the cycle after the sixth access is sampled.
- R3: The command code is selected by the sixth address: 0x8FC0 gives 0 (store), 0x4C63 gives 1 (recall), 0x8B45 gives 2 (auto-store off), 0x4B46 gives 3 (auto-store on).
- R4: Only address bits [15:0] are compared; bits above 15 have no effect on matching.
- R5: A write access at any point in the chain aborts it, and no command is issued for that chain.
- R6: A read at any address other than the next expected one aborts the chain.
- R7: The access that aborts a chain is itself tested as a first step, so a read at 0x4E38 that aborts a chain starts a new chain.
- R8: A sixth read that matches no command address aborts the chain without a pulse.
- R9: While `busy` is high, accesses are ignored and the chain returns to idle; no pulse follows a cycle with `busy` high.
- R10: Cycles with `acc_valid` low neither advance nor abort a chain.
- R11: `cmd_valid` is high for exactly one cycle per recognised command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W (20) | Access address |
| busy | input | 1 | Storage operation in progress |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Command: 0 store, 1 recall, 2 auto-store off, 3 auto-store on |

## Verification
The pulse and its code are the only results of this block. Both come from a single register stage, so they are due exactly one clock after the sixth access is sampled, and they stay low on every other cycle. The bench drives each access on a falling edge and lets one rising edge pass. It then compares both outputs at the following falling edge against a bench model that is updated with the same access. This means a pulse that arrives one cycle late, early, or for two cycles is caught on the very next comparison.

// File: rtl/seqcmd_detect.sv
module seqcmd_detect #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              busy,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code
);
  localparam int KEY_W   = 16;
  localparam int PRE_LEN = 5;
  localparam int STEP_W  = $clog2(PRE_LEN + 1);

  function automatic logic [KEY_W-1:0] key_at(input logic [STEP_W-1:0] i);
    case (i)
      3'd0:    key_at = 16'h4E38;
      3'd1:    key_at = 16'hB1C7;
      3'd2:    key_at = 16'h83E0;
      3'd3:    key_at = 16'h7C1F;
      default: key_at = 16'h703F;
    endcase
  endfunction

  logic [STEP_W-1:0] step;
  logic [KEY_W-1:0]  low;
  logic              last_step, first_hit, next_hit, op_hit;
  logic [1:0]        op_sel;
  logic              unused_hi;

  assign low       = acc_addr[KEY_W-1:0];
  assign unused_hi = ^acc_addr[ADDR_W-1:KEY_W];
  assign last_step = (step == STEP_W'(PRE_LEN));
  assign first_hit = (low == key_at('0));
  assign next_hit  = !last_step && (low == key_at(step));

  always_comb begin
    op_hit = 1'b1;
    op_sel = 2'd0;
    case (low)
      16'h8FC0: op_sel = 2'd0;
      16'h4C63: op_sel = 2'd1;
      16'h8B45: op_sel = 2'd2;
      16'h4B46: op_sel = 2'd3;
      default:  op_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= 2'd0;
    end else begin
      cmd_valid <= 1'b0;
      if (busy) begin
        step <= '0;
      end else if (acc_valid) begin
        if (acc_write) begin
          step <= '0;
        end else if (last_step && op_hit) begin
          cmd_valid <= 1'b1;
          cmd_code  <= op_sel;
          step      <= '0;
        end else if (next_hit) begin
          step <= step + 1'b1;
        end else begin
          step <= first_hit ? STEP_W'(1) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              busy,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid); // R11
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !cmd_valid); // R9
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid && acc_write) |=> !cmd_valid); // R5
  AST_IDLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |=> !cmd_valid); // R10
  AST_CMD_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> $past(acc_valid && !acc_write && !busy)); // R2
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> (cmd_valid || $stable(cmd_code))); // R3
endmodule

bind seqcmd_detect seqcmd_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
);

// File: tb/seqcmd_detect_bench.sv
module seqcmd_detect_bench;
  localparam int AW = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, busy = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic cmd_valid;
  logic [1:0] cmd_code;

  always #4 clk = ~clk;

  seqcmd_detect #(.ADDR_W(AW)) u_seqcmd_detect (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  logic [15:0] keys [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  logic [15:0] ops  [4] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};

  int n_chk = 0, n_bad = 0;
  int m_step = 0;
  logic exp_v = 1'b0;
  logic [1:0] exp_c = 2'd0;
  bit done = 0;

  function automatic int op_index(input logic [15:0] a);
    for (int i = 0; i < 4; i++) if (ops[i] == a) return i;
    return -1;
  endfunction

  task automatic model(input logic v, input logic w, input logic [15:0] a, input logic b);
    exp_v = 1'b0;
    if (b) m_step = 0;
    else if (v) begin
      if (w) m_step = 0;
      else if (m_step == 5 && op_index(a) >= 0) begin
        exp_v = 1'b1; exp_c = 2'(op_index(a)); m_step = 0;
      end else if (m_step < 5 && a == keys[m_step]) m_step++;
      else m_step = (a == keys[0]) ? 1 : 0;
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (cmd_valid !== exp_v || (exp_v && cmd_code !== exp_c)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d", tag, cmd_valid, cmd_code, exp_v, exp_c);
    end
  endtask

  task automatic acc(input logic v, input logic w, input logic [AW-1:0] a, input logic b, input string tag);
    acc_valid = v; acc_write = w; acc_addr = a; busy = b;
    model(v, w, a[15:0], b);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; busy = 1'b0;
    check(tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    acc(1'b1, 1'b0, {4'h0, a}, 1'b0, tag);
  endtask

  task automatic prefix(input int upto, input logic [3:0] hi, input string tag);
    for (int i = 0; i < upto; i++) acc(1'b1, 1'b0, {hi, keys[i]}, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    n_chk++;
    if (cmd_valid !== 1'b0 || cmd_code !== 2'd0) begin
      n_bad++;
      $display("FAIL R1: valid=%0b code=%0d expected valid=0 code=0", cmd_valid, cmd_code);
    end
    rst_n = 1'b1;
    rd(16'h8FC0, "R1 lone op after reset");
    for (int k = 0; k < 4; k++) begin
      prefix(5, 4'h0, "R2 prefix");
      rd(ops[k], "R2 R3 command code");
      acc(1'b0, 1'b0, '0, 1'b0, "R11 pulse ends");
    end
    for (int i = 0; i < 5; i++) begin
      acc(1'b1, 1'b0, {4'h0, keys[i]}, 1'b0, "R2 prefix");
      acc(1'b0, 1'b1, '0, 1'b0, "R10 idle gap");
    end
    rd(ops[1], "R10 gaps keep chain");
    prefix(5, 4'hA, "R4 upper bits");
    acc(1'b1, 1'b0, {4'h5, ops[2]}, 1'b0, "R4 upper bits ignored");
    prefix(3, 4'h0, "R5 prefix");
    acc(1'b1, 1'b1, {4'h0, keys[3]}, 1'b0, "R5 write aborts");
    for (int i = 3; i < 5; i++) rd(keys[i], "R5 rest");
    rd(ops[0], "R5 no command");
    prefix(5, 4'h0, "R5 prefix");
    acc(1'b1, 1'b1, {4'h0, ops[0]}, 1'b0, "R5 write at sixth");
    prefix(2, 4'h0, "R6 prefix");
    rd(16'h1234, "R6 wrong read");
    for (int i = 2; i < 5; i++) rd(keys[i], "R6 rest");
    rd(ops[3], "R6 no command");
    prefix(3, 4'h0, "R7 prefix");
    rd(keys[0], "R7 abort restarts");
    for (int i = 1; i < 5; i++) rd(keys[i], "R7 rest");
    rd(ops[1], "R7 command after restart");
    prefix(5, 4'h0, "R8 prefix");
    rd(16'hFFFF, "R8 unknown op");
    rd(ops[0], "R8 chain gone");
    prefix(5, 4'h0, "R8 prefix");
    rd(keys[0], "R8 R7 sixth restarts");
    for (int i = 1; i < 5; i++) rd(keys[i], "R8 rest");
    rd(ops[2], "R8 R7 command");
    prefix(4, 4'h0, "R9 prefix");
    acc(1'b0, 1'b0, '0, 1'b1, "R9 busy clears");
    rd(keys[4], "R9 rest");
    rd(ops[0], "R9 no command");
    prefix(5, 4'h0, "R9 prefix");
    acc(1'b1, 1'b0, {4'h0, ops[0]}, 1'b1, "R9 access ignored while busy");
    rd(ops[0], "R9 chain cleared");
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom % 100;
      logic [3:0] hi = 4'($urandom);
      logic [15:0] a;
      if (k < 55) a = (m_step < 5) ? keys[m_step] : ops[$urandom % 4];
      else if (k < 70) a = keys[0];
      else if (k < 82) a = ops[$urandom % 4];
      else a = 16'($urandom);
      if (k >= 97) acc(1'b1, 1'b0, {hi, a}, 1'b1, "R9 random busy");
      else if (k >= 93) acc(1'b1, 1'b1, {hi, a}, 1'b0, "R5 random write");
      else if (k >= 88) acc(1'b0, 1'b0, {hi, a}, 1'b0, "R10 random idle");
      else acc(1'b1, 1'b0, {hi, a}, 1'b0, "R2 R3 R6 random read");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule